// File: doc/BRIEF.md
# NAND Flash Bus Cycle Controller

This block sits between a simple host request port and a NAND flash device bus. Each host access is a single read or write. It becomes one device bus cycle with four programmable time windows: an address setup window, a strobe window, a hold window and a data high-impedance window for writes. Each window lasts its 8-bit register value plus one clock.

Commands and addresses go to the flash as plain writes. Two host address bits drive the command-latch and address-latch lines during the access. A third address bit picks the bank, and only that bank's chip enable falls. A per-bank enable gates whether requests are taken at all. A width setting selects an 8-bit or 16-bit data path. When ready/busy waiting is switched on, a low ready input stretches the strobe window until the device is ready.

Top module: `nand_bus_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, all chip enables, `we_n` and `oe_n` are high, `cle`, `ale`, `dq_oe` and `ack` are low, and `rdata` is zero.
- R2: An accepted access starts with a setup window of `t_setup`+1 clocks. In this window the addressed chip enable is low and both strobes are high.
- R3: The setup window is followed by a strobe window of `t_strobe`+1 clocks. On a write only `we_n` is low, and on a read only `oe_n` is low. The two strobes are never low together.
- R4: The strobe window is followed by a hold window of `t_hold`+1 clocks with both strobes high. Then comes one clock in which `ack` is high, every chip enable is high and `dq_oe` is low.
- R5: On a write, `dq_oe` stays low for the first `t_hiz`+1 clocks of the access and is high from then until the hold window ends. While it is high, `dq_o` carries `wdata`, with bits 15:8 zero in 8-bit mode.
- R6: `cle` equals host address bit 16 and `ale` equals host address bit 17 for every clock of the setup, strobe and hold windows. Both are low outside an access.
- R7: Host address bit 24 selects the bank. Only `ce_n` of that bank goes low, and at most one chip enable is low at any time.
- R8: A request to a bank whose `bank_en` bit is clear is ignored. No chip enable falls and `ack` stays low.
- R9: When `wait_en` is high and `rb_ready` is low at the clock that would end the strobe window, the strobe window is extended one clock at a time until `rb_ready` is seen high.
- R10: On a read, `dq_i` is sampled at the clock that ends the strobe window. In 16-bit mode (`wide`=1) all 16 bits are returned on `rdata`. In 8-bit mode only bits 7:0 are returned and the upper bits read zero. The value is held through the `ack` clock.
- R11: A timing value of zero gives a one-clock window for each of setup, strobe, hold and high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host access request, held until ack |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 26 | Host address; bit 16 command latch, bit 17 address latch, bit 24 bank |
| wdata | input | 16 | Host write data |
| ack | output | 1 | One-clock access completion |
| rdata | output | 16 | Read data |
| bank_en | input | 2 | Per-bank enable |
| wide | input | 1 | 1 = 16-bit data path, 0 = 8-bit |
| wait_en | input | 1 | Enables the ready/busy stall |
| t_setup | input | 8 | Setup window length minus one |
| t_strobe | input | 8 | Strobe window length minus one |
| t_hold | input | 8 | Hold window length minus one |
| t_hiz | input | 8 | Write high-impedance length minus one |
| ce_n | output | 2 | Active-low chip enables per bank |
| we_n | output | 1 | Active-low write strobe |
| oe_n | output | 1 | Active-low read strobe |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| dq_o | output | 16 | Data bus output value |
| dq_oe | output | 1 | Data bus output enable |
| dq_i | input | 16 | Data bus input value |
| rb_ready | input | 1 | Device ready (1) / busy (0) |

## Verification
The assertions assume three things. The configuration inputs (`bank_en`, `wide`, `wait_en` and the four timing values) do not change while an access is in progress. The host keeps `req`, `wr`, `addr` and `wdata` steady until it sees `ack`, and drops `req` in the clock after `ack`. The bench holds to this by changing configuration only between accesses and by releasing `req` on the falling edge of the `ack` clock. For the stall case it drives `rb_ready` low before the access starts and raises it a fixed number of clocks later, so the extension point can be predicted.

// File: rtl/nand_ctrl_pkg.sv
package nand_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_GAP    = 3'd4
  } phase_t;

endpackage

// File: rtl/nand_addr_map.sv
module nand_addr_map #(
  parameter int AW       = 26,
  parameter int NBANK    = 2,
  parameter int BANK_LSB = 24,
  parameter int CLE_BIT  = 16,
  parameter int ALE_BIT  = 17,
  localparam int BSW     = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic [AW-1:0]    addr,
  input  logic [NBANK-1:0] bank_en,
  output logic [BSW-1:0]   bank,
  output logic             bank_ok,
  output logic             cle_hit,
  output logic             ale_hit
);

  assign bank    = addr[BANK_LSB +: BSW];
  assign bank_ok = bank_en[bank];
  assign cle_hit = addr[CLE_BIT];
  assign ale_hit = addr[ALE_BIT];

endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_ctrl_pkg::*;
#(
  parameter int TW  = 8,
  localparam int EW = TW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [TW-1:0] set_v,
  input  logic [TW-1:0] wait_v,
  input  logic [TW-1:0] hold_v,
  input  logic          stall,
  output phase_t        phase,
  output logic          strobe_done,
  output logic [EW-1:0] elapsed
);

  logic [TW-1:0] cnt;

  assign strobe_done = (phase == PH_STROBE) && (cnt == wait_v) && !stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      elapsed <= '0;
    end else begin
      if (phase != PH_IDLE && !(&elapsed))
        elapsed <= elapsed + 1'b1;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase   <= PH_SETUP;
            cnt     <= '0;
            elapsed <= '0;
          end
        end
        PH_SETUP: begin
          if (cnt == set_v) begin
            phase <= PH_STROBE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_STROBE: begin
          if (cnt == wait_v) begin
            if (!stall) begin
              phase <= PH_HOLD;
              cnt   <= '0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt == hold_v) begin
            phase <= PH_GAP;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_GAP:  phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R4: a completion clock is always followed by idle
  p_gap_then_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_GAP) |=> (phase == PH_IDLE));

  // R9: a stalled strobe end keeps the strobe window open
  p_stall_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STROBE && stall && cnt == wait_v) |=> (phase == PH_STROBE));

endmodule

// File: rtl/nand_bus_ctrl.sv
module nand_bus_ctrl
  import nand_ctrl_pkg::*;
#(
  parameter int AW       = 26,
  parameter int DW       = 16,
  parameter int NBANK    = 2,
  parameter int TW       = 8,
  parameter int BANK_LSB = 24,
  parameter int CLE_BIT  = 16,
  parameter int ALE_BIT  = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic             ack,
  output logic [DW-1:0]    rdata,
  input  logic [NBANK-1:0] bank_en,
  input  logic             wide,
  input  logic             wait_en,
  input  logic [TW-1:0]    t_setup,
  input  logic [TW-1:0]    t_strobe,
  input  logic [TW-1:0]    t_hold,
  input  logic [TW-1:0]    t_hiz,
  output logic [NBANK-1:0] ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             cle,
  output logic             ale,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe,
  input  logic [DW-1:0]    dq_i,
  input  logic             rb_ready
);

  localparam int BSW = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int NW  = DW / 2;
  localparam int EW  = TW + 2;

  logic [BSW-1:0] dec_bank;
  logic           dec_ok, dec_cle, dec_ale;
  phase_t         phase;
  logic           strobe_done, start, in_acc;
  logic [EW-1:0]  elapsed;

  logic           a_wr, a_cle, a_ale;
  logic [BSW-1:0] a_bank;
  logic [DW-1:0]  a_wdata;

  nand_addr_map #(
    .AW(AW), .NBANK(NBANK), .BANK_LSB(BANK_LSB),
    .CLE_BIT(CLE_BIT), .ALE_BIT(ALE_BIT)
  ) u_map (
    .addr(addr), .bank_en(bank_en), .bank(dec_bank),
    .bank_ok(dec_ok), .cle_hit(dec_cle), .ale_hit(dec_ale)
  );

  assign start = req && dec_ok && (phase == PH_IDLE);

  nand_phase_seq #(.TW(TW)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .set_v(t_setup), .wait_v(t_strobe), .hold_v(t_hold),
    .stall(wait_en && !rb_ready),
    .phase(phase), .strobe_done(strobe_done), .elapsed(elapsed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_wr    <= 1'b0;
      a_cle   <= 1'b0;
      a_ale   <= 1'b0;
      a_bank  <= '0;
      a_wdata <= '0;
      rdata   <= '0;
    end else begin
      if (start) begin
        a_wr    <= wr;
        a_cle   <= dec_cle;
        a_ale   <= dec_ale;
        a_bank  <= dec_bank;
        a_wdata <= wide ? wdata : {{(DW-NW){1'b0}}, wdata[NW-1:0]};
      end
      if (strobe_done && !a_wr)
        rdata <= wide ? dq_i : {{(DW-NW){1'b0}}, dq_i[NW-1:0]};
    end
  end

  assign in_acc = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_ce
      localparam logic [BSW-1:0] BI = BSW'(b);
      assign ce_n[b] = !(in_acc && a_bank == BI);
    end
  endgenerate

  assign we_n  = !((phase == PH_STROBE) && a_wr);
  assign oe_n  = !((phase == PH_STROBE) && !a_wr);
  assign cle   = in_acc && a_cle;
  assign ale   = in_acc && a_ale;
  assign dq_oe = in_acc && a_wr && (elapsed > EW'(t_hiz));
  assign dq_o  = a_wdata;
  assign ack   = (phase == PH_GAP);

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(!we_n && !oe_n));

  p_one_ce_r7: assert property (@(posedge clk) disable iff (rst)
    $countones(~ce_n) <= 1);

  p_ack_released_r4: assert property (@(posedge clk) disable iff (rst)
    ack |-> (&ce_n && !dq_oe));

  p_ack_single_r4: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  p_drive_only_write_r5: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> oe_n);

  p_enabled_bank_r8: assert property (@(posedge clk) disable iff (rst)
    ((~ce_n) & ~bank_en) == '0);

  p_latch_in_access_r6: assert property (@(posedge clk) disable iff (rst)
    (cle || ale) |-> !(&ce_n));

endmodule

// File: tb/nand_bus_ctrl_test.sv
module nand_bus_ctrl_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst = 1;
  logic req = 0, wr = 0;
  logic [25:0] addr = '0;
  logic [15:0] wdata = '0;
  logic ack;
  logic [15:0] rdata;
  logic [1:0] bank_en = 2'b11;
  logic wide = 0, wait_en = 0;
  logic [7:0] t_setup = 0, t_strobe = 0, t_hold = 0, t_hiz = 0;
  logic [1:0] ce_n;
  logic we_n, oe_n, cle, ale, dq_oe;
  logic [15:0] dq_o;
  logic [15:0] dq_i = 16'h1234;
  logic rb_ready = 1;

  int checks = 0, errors = 0;
  string scen = "R1";
  bit done = 0;

  nand_bus_ctrl uut (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ack(ack), .rdata(rdata), .bank_en(bank_en), .wide(wide), .wait_en(wait_en),
    .t_setup(t_setup), .t_strobe(t_strobe), .t_hold(t_hold), .t_hiz(t_hiz),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .cle(cle), .ale(ale),
    .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i), .rb_ready(rb_ready)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s [%s] actual=%h expected=%h at %0t", tag, scen, act, exp, $time);
    end
  endtask

  // behavioural reference: cycle index within the access and window boundaries
  bit m_busy = 0;
  int m_k = 0, s_end = 0, w_end = 0, h_end = 0, m_hiz = 0;
  bit m_wr = 0, m_cle = 0, m_ale = 0;
  int m_bank = 0;
  logic [15:0] m_wd = 0, m_rd = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_rd = 0;
    end else if (!m_busy) begin
      if (req && bank_en[addr[24]]) begin
        m_busy = 1; m_k = 0;
        s_end = t_setup + 1;
        w_end = s_end + t_strobe + 1;
        h_end = w_end + t_hold + 1;
        m_hiz = t_hiz + 1;
        m_wr = wr; m_cle = addr[16]; m_ale = addr[17]; m_bank = addr[24];
        m_wd = wide ? wdata : {8'h00, wdata[7:0]};
      end
    end else if (m_k == h_end) begin
      m_busy = 0;
    end else begin
      if (m_k == w_end - 1) begin
        if (wait_en && !rb_ready) begin
          w_end++; h_end++;
        end else if (!m_wr) begin
          m_rd = wide ? dq_i : {8'h00, dq_i[7:0]};
        end
      end
      m_k++;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      automatic bit acc = m_busy && m_k < h_end;
      automatic bit stb = m_busy && m_k >= s_end && m_k < w_end;
      automatic bit e_ack = m_busy && m_k == h_end;
      automatic bit e_oe = acc && m_wr && m_k >= m_hiz;
      for (int b = 0; b < 2; b++)
        chk(ce_n[b] == !(acc && m_bank == b), "R7 ce_n", ce_n[b], !(acc && m_bank == b));
      chk(we_n == !(stb && m_wr), "R3 we_n", we_n, !(stb && m_wr));
      chk(oe_n == !(stb && !m_wr), "R3 oe_n", oe_n, !(stb && !m_wr));
      chk(cle == (acc && m_cle), "R6 cle", cle, acc && m_cle);
      chk(ale == (acc && m_ale), "R6 ale", ale, acc && m_ale);
      chk(dq_oe == e_oe, "R5 dq_oe", dq_oe, e_oe);
      if (e_oe) chk(dq_o == m_wd, "R5 dq_o", dq_o, m_wd);
      chk(ack == e_ack, "R4 ack", ack, e_ack);
      if (e_ack) chk(rdata == m_rd, "R10 rdata", rdata, m_rd);
    end
    dq_i <= dq_i + 16'h1357;
  end

  task automatic access(input bit w, input logic [25:0] a, input logic [15:0] d);
    @(negedge clk);
    req = 1; wr = w; addr = a; wdata = d;
    do @(negedge clk); while (!ack);
    req = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ce_n == 2'b11 && we_n && oe_n && !cle && !ale && !dq_oe && !ack && rdata == 0,
        "R1 reset outputs", {ce_n, we_n, oe_n, cle, ale, dq_oe, ack}, 8'hF0);
    rst = 0;
    @(negedge clk);
    chk(ce_n == 2'b11 && !ack, "R1 after reset", {ce_n, ack}, 3'b110);

    // R2/R3/R4/R6: command write, bank 0, 8-bit
    scen = "R2"; t_setup = 1; t_strobe = 2; t_hold = 1; t_hiz = 0;
    access(1, 26'h001_0000, 16'hAB00);
    // address-latch write with extended hiz
    scen = "R5"; t_hiz = 3;
    access(1, 26'h002_0000, 16'h5A3C);
    // all-zero timing, 16-bit read from bank 1
    scen = "R11"; t_setup = 0; t_strobe = 0; t_hold = 0; t_hiz = 0; wide = 1;
    access(0, 26'h100_0000, 16'h0);
    access(1, 26'h100_0004, 16'hBEEF);
    // 8-bit read
    scen = "R10"; wide = 0; t_strobe = 3;
    access(0, 26'h000_0010, 16'h0);
    // ready/busy stall
    scen = "R9"; wait_en = 1; rb_ready = 0; t_strobe = 1; wide = 1;
    fork
      access(0, 26'h100_0020, 16'h0);
      begin repeat (8) @(negedge clk); rb_ready = 1; end
    join
    // wait enabled but device ready: no stretch
    access(1, 26'h003_0000, 16'h7788);
    wait_en = 0;
    // R8: request to disabled bank
    scen = "R8"; bank_en = 2'b01;
    @(negedge clk);
    req = 1; wr = 1; addr = 26'h100_0000; wdata = 16'h1111;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!ack && ce_n == 2'b11, "R8 ignored request", {ce_n, ack}, 3'b110);
    end
    req = 0;
    @(negedge clk);
    bank_en = 2'b11;
    // back-to-back to both banks
    scen = "R7"; t_setup = 2; t_hold = 2;
    access(0, 26'h000_0100, 16'h0);
    access(0, 26'h100_0100, 16'h0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule